// File: doc/BRIEF.md
# Third-Order Comb Interpolation Filter

This block raises the sample rate of a stream of 16-bit two's-complement words by a selectable factor of 2, 4, 8 or 16. One word arrives every 16 cycles of the bit clock, marked by a one-cycle load strobe. The block produces that many interpolated samples per word, each with a one-cycle update strobe. The samples are spread evenly across the 16-cycle frame.

The filter is a cascade of three combs running at the word rate, then zero-stuffing and three integrators running at the output rate. Its response is the cube of a length-N box, which traces a quadratic spline through the input words. Every output is a weighted blend of the newest word and the two words before it, so the delay is two frames whatever the ratio.

The accumulators carry 12 guard bits. That is enough for full-scale growth at 16x, so two's-complement wrap inside the integrators cancels exactly. The result is divided by N squared with an arithmetic shift, which rounds towards minus infinity, and is then clamped to 16 bits. The ratio is latched once after each reset.

Top module: `comb3_interp`

## Requirements
- R1: The latched ratio code selects the number of outputs per accepted word: code 0 gives 2, code 1 gives 4, code 2 gives 8 and code 3 gives 16. A frame in which no word arrives produces no outputs.
- R2: With words arriving exactly 16 cycles apart, consecutive outputs of a frame are 16/N cycles apart.
- R3: The output at position k (0..N-1) of the frame that accepted word x[n] is floor((a*x[n] + b*x[n-1] + c*x[n-2]) / N^2). Here a = (k+1)(k+2)/2, c = (N-1-k)(N-2-k)/2 and b = N^2 - a - c.
- R4: Before real words exist, the earlier words x[n-1] and x[n-2] are taken as 0, the mid-scale code.
- R5: When the same word arrives in two consecutive frames, the last output of the second frame equals that word exactly.
- R6: An active-low asynchronous reset immediately forces the sample output to 0 and the update strobe low. It also clears all word history and filter state.
- R7: The ratio code is captured at the first clock edge after reset is released. Changing it afterwards has no effect until the next reset.
- R8: Outputs never wrap. Runs of full-scale words 0x7FFF and 0x8000 give outputs within and reaching those limits, and any result beyond the 16-bit range is clamped.
- R9: The first output of a frame appears with its strobe in the second cycle after the cycle in which the load strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ratioSel | input | 2 | Interpolation ratio code, latched after reset |
| wordIn | input | 16 | Input word, two's complement |
| wordLoad | input | 1 | One-cycle strobe accepting wordIn, once per 16 cycles |
| sampleOut | output | 16 | Interpolated output sample, two's complement |
| sampleValid | output | 1 | One-cycle strobe marking a new sampleOut |

## Verification
On every cycle, the assertions check the following properties:
- the output is quiet while reset is held;
- the latched ratio never moves after its capture edge;
- each load strobe is followed two cycles later by an update strobe;
- update strobes are never closer together than the ratio's spacing.

The numeric behaviour can only be shown by the scenarios. These cover the spline weights against the three-word history, the zero history after reset, exact reproduction of a repeated word, clamping at full scale, and output counts that stop when words stop. They rely on a scoreboard that predicts every sample from the weight formula.

// File: rtl/comb3_interp_pkg.sv
package comb3_interp_pkg;
  localparam int RATIO_W = 2;

  typedef struct packed {
    logic combLoad;
    logic tick;
    logic inject;
  } ctlStrobes_t;
endpackage

// File: rtl/comb3_interp_ctrl.sv
module comb3_interp_ctrl
  import comb3_interp_pkg::*;
#(
  parameter int FRAME_LEN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               wordLoad,
  output logic [RATIO_W-1:0] ratioQ,
  output ctlStrobes_t        strobes
);
  localparam int PHASE_W = $clog2(FRAME_LEN);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(FRAME_LEN - 1);

  logic               armed;
  logic               live;
  logic               pending;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W:0]   stepLen;
  logic [PHASE_W-1:0] stepMask;
  logic               rawTick;

  always_comb begin
    stepLen  = (PHASE_W + 1)'(FRAME_LEN) >> ({1'b0, ratioQ} + 3'd1);
    stepMask = PHASE_W'(stepLen - 1'b1);
    rawTick  = (phase & stepMask) == '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      ratioQ  <= '0;
      phase   <= '0;
      live    <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (!armed) begin
        armed  <= 1'b1;
        ratioQ <= ratioSel;
      end
      phase <= wordLoad ? '0 : phase + 1'b1;
      if (wordLoad) live <= 1'b1;
      else if (phase == LAST_PHASE) live <= 1'b0;
      if (wordLoad) pending <= 1'b1;
      else if (rawTick && live) pending <= 1'b0;
    end
  end

  assign strobes.combLoad = wordLoad;
  assign strobes.tick     = rawTick && live;
  assign strobes.inject   = rawTick && live && pending;
endmodule

// File: rtl/comb3_interp_dp.sv
module comb3_interp_dp
  import comb3_interp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LOG = 4,
  parameter int ORDER   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [RATIO_W-1:0] ratioQ,
  input  logic [DATA_W-1:0]  wordIn,
  output logic [DATA_W-1:0]  sampleOut,
  output logic               sampleValid
);
  localparam int ACC_W = DATA_W + ORDER * MAX_LOG;
  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0] combChain [ORDER+1];
  logic signed [ACC_W-1:0] integNext [ORDER];
  logic signed [ACC_W-1:0] injectVal;
  logic signed [ACC_W-1:0] scaled;
  logic [3:0]              shiftAmt;
  logic [DATA_W-1:0]       clamped;

  assign combChain[0] = {{(ACC_W-DATA_W){wordIn[DATA_W-1]}}, wordIn};

  for (genvar s = 0; s < ORDER; s++) begin : g_comb
    logic signed [ACC_W-1:0] hist;
    assign combChain[s+1] = combChain[s] - hist;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hist <= '0;
      else if (strobes.combLoad) hist <= combChain[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) injectVal <= '0;
    else if (strobes.combLoad) injectVal <= combChain[ORDER];
  end

  for (genvar s = 0; s < ORDER; s++) begin : g_integ
    logic signed [ACC_W-1:0] acc;
    if (s == 0) begin : g_head
      assign integNext[s] = acc + (strobes.inject ? injectVal : '0);
    end else begin : g_body
      assign integNext[s] = acc + integNext[s-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) acc <= '0;
      else if (strobes.tick) acc <= integNext[s];
    end
  end

  always_comb begin
    shiftAmt = {1'b0, ratioQ, 1'b0} + 4'd2;
    scaled   = integNext[ORDER-1] >>> shiftAmt;
    if (scaled > SAT_HI)      clamped = {1'b0, {(DATA_W-1){1'b1}}};
    else if (scaled < SAT_LO) clamped = {1'b1, {(DATA_W-1){1'b0}}};
    else                      clamped = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.tick;
      if (strobes.tick) sampleOut <= clamped;
    end
  end
endmodule

// File: rtl/comb3_interp.sv
module comb3_interp
  import comb3_interp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 16,
  parameter int MAX_LOG   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic [DATA_W-1:0]  wordIn,
  input  logic               wordLoad,
  output logic [DATA_W-1:0]  sampleOut,
  output logic               sampleValid
);
  ctlStrobes_t        strobes;
  logic [RATIO_W-1:0] ratioQ;

  comb3_interp_ctrl #(.FRAME_LEN(FRAME_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .wordLoad(wordLoad),
    .ratioQ(ratioQ), .strobes(strobes)
  );

  comb3_interp_dp #(.DATA_W(DATA_W), .MAX_LOG(MAX_LOG), .ORDER(3)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ratioQ(ratioQ), .wordIn(wordIn),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );
endmodule

// File: rtl/comb3_interp_chk.sv
module comb3_interp_chk
  import comb3_interp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wordLoad,
  input logic               sampleValid,
  input logic [DATA_W-1:0]  sampleOut,
  input logic [RATIO_W-1:0] ratioQ
);
  logic       firstDone;
  logic       seenValid;
  logic [7:0] gap;
  logic [7:0] stepNow;

  assign stepNow = 8'(FRAME_LEN) >> ({1'b0, ratioQ} + 3'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstDone <= 1'b0;
      seenValid <= 1'b0;
      gap       <= '0;
    end else begin
      firstDone <= 1'b1;
      if (sampleValid) begin
        seenValid <= 1'b1;
        gap       <= 8'd1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 8'd1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r6: assert (sampleOut == '0 && !sampleValid)
        else $error("output active during reset");
    end
  end

  p_ratio_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    firstDone |=> $stable(ratioQ));

  p_load_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    wordLoad |=> ##1 sampleValid);

  p_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && seenValid) |-> (gap >= stepNow));
endmodule

bind comb3_interp comb3_interp_chk #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) i_chk (
  .clk(clk), .rstN(rstN), .wordLoad(wordLoad), .sampleValid(sampleValid),
  .sampleOut(sampleOut), .ratioQ(ratioQ)
);

// File: tb/test_comb3_interp.sv
module test_comb3_interp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  ratioSel = 2'b11;
  logic [15:0] wordIn = '0;
  logic        wordLoad = 1'b0;
  logic [15:0] sampleOut;
  logic        sampleValid;

  comb3_interp i_comb3_interp (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .wordIn(wordIn),
    .wordLoad(wordLoad), .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [15:0] val;
    string       tag;
    int          k;
    longint      loadCyc;
  } item_t;

  item_t  q[$];
  item_t  it;
  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  longint lastV = 0;
  int     step = 1;
  int     curRatio = 3;
  longint h1 = 0;
  longint h2 = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  function automatic logic [15:0] model(input int r, input int k,
                                        input longint x0, input longint x1, input longint x2);
    longint n, a, b, c, s, y;
    n = longint'(1) << (r + 1);
    a = (k + 1) * (k + 2) / 2;
    c = (n - 1 - k) * (n - 2 - k) / 2;
    b = n * n - a - c;
    s = a * x0 + b * x1 + c * x2;
    y = s >>> (2 * (r + 1));
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y[15:0];
  endfunction

  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1", "sample with nothing expected", longint'(sampleOut), 0);
      end else begin
        it = q.pop_front();
        chk(sampleOut == it.val, it.tag, $sformatf("sample k=%0d", it.k),
            longint'($signed(sampleOut)), longint'($signed(it.val)));
        if (it.k == 0)
          chk(cyc - it.loadCyc == 2, "R9", "first-output latency", cyc - it.loadCyc, 2);
        else
          chk(cyc - lastV == step, "R2", "output spacing", cyc - lastV, step);
      end
      lastV = cyc;
    end
  end

  task automatic doReset(input logic [1:0] r);
    @(negedge clk);
    rstN = 1'b0;
    ratioSel = r;
    wordLoad = 1'b0;
    #1;
    chk(sampleOut == 16'h0000 && !sampleValid, "R6", "output during reset",
        longint'(sampleOut), 0);
    q.delete();
    h1 = 0;
    h2 = 0;
    curRatio = int'(r);
    step = 16 >> (curRatio + 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [15:0] w, input string tag);
    item_t  e;
    longint x0;
    int     n;
    @(negedge clk);
    wordLoad = 1'b1;
    wordIn = w;
    x0 = longint'($signed(w));
    n = 1 << (curRatio + 1);
    for (int k = 0; k < n; k++) begin
      e.val = model(curRatio, k, x0, h1, h2);
      e.tag = tag;
      e.k = k;
      e.loadCyc = cyc;
      q.push_back(e);
    end
    h2 = h1;
    h1 = x0;
    @(negedge clk);
    wordLoad = 1'b0;
    wordIn = ~w;
    repeat (14) @(negedge clk);
  endtask

  task automatic runSession(input logic [1:0] r, input logic [15:0] w[$],
                            input string t[$], input int changeAt, input bit abortEnd);
    doReset(r);
    for (int i = 0; i < w.size(); i++) begin
      if (i == changeAt) ratioSel = ~r;
      sendFrame(w[i], t[i]);
    end
    if (!abortEnd) begin
      repeat (24) @(negedge clk);
      chk(q.size() == 0, "R1", "outputs missing at end of run", q.size(), 0);
    end
  endtask

  initial begin
    runSession(2'b11,
      '{16'h1000, 16'h1000, 16'h2000, 16'hF000, 16'h0000,
        16'h7FFF, 16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF},
      '{"R4", "R5", "R3", "R3", "R7", "R7", "R8", "R8", "R8", "R8"}, 4, 1'b0);
    runSession(2'b00,
      '{16'h0123, 16'hFBAA, 16'h7FFF, 16'h7FFF, 16'h0005, 16'h0005},
      '{"R4", "R1", "R1", "R5", "R2", "R2"}, -1, 1'b1);
    runSession(2'b01,
      '{16'h8000, 16'h4000, 16'h4000, 16'hC000, 16'h1234},
      '{"R6", "R3", "R5", "R1", "R2"}, -1, 1'b0);
    runSession(2'b10,
      '{16'h7FFF, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h2222},
      '{"R8", "R3", "R3", "R5", "R2"}, 2, 1'b0);
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end
endmodule